// File: doc/BRIEF.md
# SDRAM Mode Register Load Decoder

This block sits on the memory side of a DDR SDRAM command bus. On every rising clock edge it samples the registered command strobes, the bank-address pair and the row/column address bus. It recognises the mode-load command and keeps two configuration words: a base word and an extended word. From these words it drives the decoded settings that the rest of a memory model needs. These settings are the burst length as a location count, the burst ordering, the read latency in half-clock units and the DLL enable.

A base load whose operating-mode field requests a DLL reset produces a single-cycle reset pulse. The stored copy of that request bit always reads back as zero. Each load is checked before it is applied. A reserved burst-length code, a reserved latency code, a reserved operating mode, an unknown target register, or a load while any bank is open is rejected. A rejected load leaves both words untouched and raises an error flag for one cycle.

Top module: `mrd_mode_decoder`

## Requirements
- R1: A load command is cs_n, ras_n, cas_n and we_n all low at a rising edge. Any other command leaves both stored words unchanged and raises no error.
- R2: The bank address selects the target. ba=2'b00 selects the base word and ba=2'b01 selects the extended word. A load with ba[1]=1 is rejected.
- R3: Base bits addr[2:0] hold the burst-length code: 1 gives burst_len=2, 2 gives 4, 3 gives 8. Every other code is reserved and is rejected.
- R4: Base bit addr[3] selects the burst order: 0 drives burst_interleave=0 (sequential) and 1 drives burst_interleave=1 (interleaved).
- R5: Base bits addr[6:4] hold the latency code: 2 gives cas_halves=4, 6 gives cas_halves=5, 3 gives cas_halves=6. Every other code is reserved and is rejected.
- R6: Base bits addr[12:7] hold the operating mode. 6'b000000 is normal operation and 6'b000010 (addr[8]=1) requests a DLL reset. Every other value is reserved and is rejected.
- R7: dll_rst is high for exactly the one cycle after the edge that accepts a base load with addr[8]=1. mode_word[8] always reads 0.
- R8: A load sampled while banks_idle is low is rejected, whatever its target.
- R9: After the edge that samples a rejected load, cfg_err is high for exactly one cycle, and mode_word and ext_word keep their previous values.
- R10: Extended bit addr[0] is the DLL disable bit. dll_en equals the inverse of ext_word[0], and the whole 13-bit address is stored in ext_word.
- R11: While rst is high at an edge, the block returns to mode_word=13'h021 (burst 2, sequential, latency 2), ext_word=0 and dll_en=1, with dll_rst and cfg_err low.
- R12: An accepted load is visible on every output in the cycle that follows its sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, selects the target word |
| addr | input | 13 | Address bus carrying the load data |
| banks_idle | input | 1 | High when no bank is open and no burst runs |
| burst_len | output | 4 | Burst length as a location count |
| burst_interleave | output | 1 | 1 for interleaved order, 0 for sequential |
| cas_halves | output | 3 | Read latency in half clocks |
| dll_en | output | 1 | DLL enabled |
| dll_rst | output | 1 | One-cycle DLL reset pulse |
| cfg_err | output | 1 | One-cycle flag for a rejected load |
| mode_word | output | 13 | Stored base word, bit 8 always 0 |
| ext_word | output | 13 | Stored extended word |

## Verification
The bench sends loads with each kind of reserved field and confirms that the settings stay put. A design that checked only some fields would take on a half-valid setting, such as a zero burst length. Loads while a bank is open, and loads to the unknown target, probe the gating; a design that skipped it would change the words without any error. The DLL reset pulse is checked for width and for the bit 8 readback, which catches a sticky request bit or a pulse that lasts more than one cycle. A non-load command carrying a full address is sent to catch partial command decoding.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Field positions inside the base word (behaviour depends on them)
  localparam int BL_LSB     = 0;
  localparam int BL_W       = 3;
  localparam int BT_BIT     = 3;
  localparam int CL_LSB     = 4;
  localparam int CL_W       = 3;
  localparam int OP_LSB     = 7;
  localparam int DLLRST_BIT = 8;
  localparam int DLLDIS_BIT = 0;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_BASE = 2'd1,
    TGT_EXT  = 2'd2,
    TGT_BAD  = 2'd3
  } target_e;

  // Burst-length code to location count; 0 marks a reserved code
  function automatic logic [3:0] bl_count(input logic [BL_W-1:0] code);
    case (code)
      3'd1:    bl_count = 4'd2;
      3'd2:    bl_count = 4'd4;
      3'd3:    bl_count = 4'd8;
      default: bl_count = 4'd0;
    endcase
  endfunction

  // Latency code to half-clock count; 0 marks a reserved code
  function automatic logic [2:0] cl_halves(input logic [CL_W-1:0] code);
    case (code)
      3'd2:    cl_halves = 3'd4;
      3'd6:    cl_halves = 3'd5;
      3'd3:    cl_halves = 3'd6;
      default: cl_halves = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrd_cmd_decode.sv
module mrd_cmd_decode
  import mrd_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  output logic            is_load,
  output target_e         target
);

  always_comb begin
    is_load = !cs_n && !ras_n && !cas_n && !we_n;
    if (!is_load)
      target = TGT_NONE;
    else if (ba[BA_W-1:1] != '0)
      target = TGT_BAD;
    else if (ba[0])
      target = TGT_EXT;
    else
      target = TGT_BASE;
  end

endmodule

// File: rtl/mrd_field_check.sv
module mrd_field_check
  import mrd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  target_e           target,
  input  logic              banks_idle,
  output logic              accept_base,
  output logic              accept_ext,
  output logic              reject
);

  localparam int OP_W = ADDR_W - OP_LSB;

  logic [OP_W-1:0] stray;
  logic            op_ok;
  logic            bl_ok;
  logic            cl_ok;
  logic            base_ok;

  // Every operating-mode bit other than the DLL-reset bit must be zero
  for (genvar gi = 0; gi < OP_W; gi++) begin : g_op
    if (gi + OP_LSB == DLLRST_BIT) begin : g_skip
      assign stray[gi] = 1'b0;
    end else begin : g_bit
      assign stray[gi] = addr[gi + OP_LSB];
    end
  end

  always_comb begin
    op_ok   = (stray == '0);
    bl_ok   = (bl_count(addr[BL_LSB +: BL_W]) != 4'd0);
    cl_ok   = (cl_halves(addr[CL_LSB +: CL_W]) != 3'd0);
    base_ok = op_ok && bl_ok && cl_ok;

    accept_base = (target == TGT_BASE) && banks_idle && base_ok;
    accept_ext  = (target == TGT_EXT) && banks_idle;
    reject      = (target != TGT_NONE) && !accept_base && !accept_ext;
  end

endmodule

// File: rtl/mrd_reg_bank.sv
module mrd_reg_bank
  import mrd_pkg::*;
#(
  parameter int                ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] RESET_BASE = 'h021,
  parameter logic [ADDR_W-1:0] RESET_EXT  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_base,
  input  logic              accept_ext,
  input  logic              reject,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] ext_q,
  output logic              pulse_q,
  output logic              err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= RESET_BASE;
      ext_q   <= RESET_EXT;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      err_q   <= reject;
      if (accept_base) begin
        base_q             <= addr;
        base_q[DLLRST_BIT] <= 1'b0;
        pulse_q            <= addr[DLLRST_BIT];
      end
      if (accept_ext) begin
        ext_q <= addr;
      end
    end
  end

endmodule

// File: rtl/mrd_mode_decoder.sv
module mrd_mode_decoder
  import mrd_pkg::*;
#(
  parameter int                ADDR_W     = 13,
  parameter int                BA_W       = 2,
  parameter logic [ADDR_W-1:0] RESET_BASE = 'h021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_halves,
  output logic              dll_en,
  output logic              dll_rst,
  output logic              cfg_err,
  output logic [ADDR_W-1:0] mode_word,
  output logic [ADDR_W-1:0] ext_word
);

  logic    is_load;
  target_e target;
  logic    accept_base;
  logic    accept_ext;
  logic    reject;

  mrd_cmd_decode #(.BA_W(BA_W)) cmd_i (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .is_load (is_load),
    .target  (target)
  );

  mrd_field_check #(.ADDR_W(ADDR_W)) chk_fields_i (
    .addr        (addr),
    .target      (target),
    .banks_idle  (banks_idle),
    .accept_base (accept_base),
    .accept_ext  (accept_ext),
    .reject      (reject)
  );

  mrd_reg_bank #(
    .ADDR_W     (ADDR_W),
    .RESET_BASE (RESET_BASE),
    .RESET_EXT  ('0)
  ) regs_i (
    .clk         (clk),
    .rst         (rst),
    .accept_base (accept_base),
    .accept_ext  (accept_ext),
    .reject      (reject),
    .addr        (addr),
    .base_q      (mode_word),
    .ext_q       (ext_word),
    .pulse_q     (dll_rst),
    .err_q       (cfg_err)
  );

  // Settings decode straight from the stored flops
  always_comb begin
    burst_len        = bl_count(mode_word[BL_LSB +: BL_W]);
    burst_interleave = mode_word[BT_BIT];
    cas_halves       = cl_halves(mode_word[CL_LSB +: CL_W]);
    dll_en           = !ext_word[DLLDIS_BIT];
  end

endmodule

// File: rtl/mrd_mode_decoder_chk.sv
module mrd_mode_decoder_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              banks_idle,
  input logic [3:0]        burst_len,
  input logic              dll_rst,
  input logic              cfg_err,
  input logic [ADDR_W-1:0] mode_word,
  input logic [ADDR_W-1:0] ext_word
);

  logic load_seen;
  assign load_seen = !cs_n && !ras_n && !cas_n && !we_n;

  a_r9_err_keeps_words: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> ($stable(mode_word) && $stable(ext_word)));

  a_r1_err_needs_load: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(load_seen));

  a_r1_quiet_keeps_words: assert property (@(posedge clk) disable iff (rst)
    !$past(load_seen) |-> ($stable(mode_word) && $stable(ext_word)));

  a_r7_pulse_source: assert property (@(posedge clk) disable iff (rst)
    dll_rst |-> $past(load_seen && ba == '0 && addr[8] && banks_idle));

  a_r7_a8_reads_zero: assert property (@(posedge clk) disable iff (rst)
    mode_word[8] == 1'b0);

  a_r7_pulse_not_err: assert property (@(posedge clk) disable iff (rst)
    dll_rst |-> !cfg_err);

  a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
    ($countones(burst_len) == 1) && !burst_len[0]);

  a_r8_busy_no_change: assert property (@(posedge clk) disable iff (rst)
    $past(!banks_idle) |-> ($stable(mode_word) && $stable(ext_word)));

endmodule

bind mrd_mode_decoder mrd_mode_decoder_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .banks_idle (banks_idle),
  .burst_len  (burst_len),
  .dll_rst    (dll_rst),
  .cfg_err    (cfg_err),
  .mode_word  (mode_word),
  .ext_word   (ext_word)
);

// File: tb/mrd_mode_decoder_tb.sv
module mrd_mode_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        banks_idle;
  logic [3:0]  burst_len;
  logic        burst_interleave;
  logic [2:0]  cas_halves;
  logic        dll_en, dll_rst, cfg_err;
  logic [12:0] mode_word, ext_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  mrd_mode_decoder dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_halves(cas_halves),
    .dll_en(dll_en), .dll_rst(dll_rst), .cfg_err(cfg_err),
    .mode_word(mode_word), .ext_word(ext_word)
  );

  typedef struct packed {
    logic        idle;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  bl;
    logic        bt;
    logic [2:0]  clh;
    logic        dll;
    logic        pulse;
    logic        err;
  } vec_t;

  // idle, ba, addr -> expected burst_len, interleave, halves, dll_en, dll_rst, cfg_err
  localparam vec_t VEC [0:11] = '{
    '{1'b1, 2'b00, 13'h062, 4'd4, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0}, // R3 R5 BL4 CL2.5
    '{1'b1, 2'b00, 13'h13B, 4'd8, 1'b1, 3'd6, 1'b1, 1'b1, 1'b0}, // R4 R7 BL8 ilv CL3 dll reset
    '{1'b1, 2'b00, 13'h020, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1}, // R3 reserved length 0
    '{1'b1, 2'b00, 13'h012, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1}, // R5 reserved latency 1
    '{1'b1, 2'b00, 13'h0A2, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1}, // R6 reserved mode A7
    '{1'b0, 2'b00, 13'h022, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1}, // R8 bank open
    '{1'b1, 2'b01, 13'h001, 4'd8, 1'b1, 3'd6, 1'b0, 1'b0, 1'b0}, // R10 dll disabled
    '{1'b0, 2'b01, 13'h000, 4'd8, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1}, // R8 ext while busy
    '{1'b1, 2'b01, 13'h000, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b0}, // R10 dll enabled
    '{1'b1, 2'b10, 13'h021, 4'd8, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1}, // R2 unknown target
    '{1'b1, 2'b00, 13'h021, 4'd2, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0}, // R3 R5 BL2 CL2
    '{1'b1, 2'b00, 13'h027, 4'd2, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1}  // R3 reserved length 7
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nop();
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic issue(input logic r, input logic c, input logic w,
                       input logic [1:0] b, input logic [12:0] a, input logic idle);
    cs_n = 1'b0; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a; banks_idle = idle;
    @(posedge clk);
    @(negedge clk);
    nop();
    banks_idle = 1'b1;
  endtask

  task automatic check_reset_state(input string req);
    check(req, mode_word, 13'h021);
    check(req, ext_word, 0);
    check(req, burst_len, 2);
    check(req, cas_halves, 4);
    check(req, dll_en, 1);
    check(req, dll_rst, 0);
    check(req, cfg_err, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; nop(); ba = 2'b00; addr = '0; banks_idle = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("R11");

    for (int i = 0; i < 12; i++) begin
      issue(1'b0, 1'b0, 1'b0, VEC[i].ba, VEC[i].addr, VEC[i].idle);
      check("R12 R3 burst_len", burst_len, VEC[i].bl);
      check("R4 interleave", burst_interleave, VEC[i].bt);
      check("R5 cas_halves", cas_halves, VEC[i].clh);
      check("R10 dll_en", dll_en, VEC[i].dll);
      check("R7 dll_rst", dll_rst, VEC[i].pulse);
      check("R9 cfg_err", cfg_err, VEC[i].err);
    end

    // R9: error is one cycle wide
    issue(1'b0, 1'b0, 1'b0, 2'b00, 13'h0C1, 1'b1);
    check("R6 reserved mode err", cfg_err, 1);
    @(negedge clk);
    check("R9 err one cycle", cfg_err, 0);
    check("R9 base kept", mode_word, 13'h021);

    // R1: activate-like command with a full load pattern changes nothing
    issue(1'b0, 1'b1, 1'b1, 2'b00, 13'h13B, 1'b1);
    check("R1 non-load base", mode_word, 13'h021);
    check("R1 non-load err", cfg_err, 0);
    issue(1'b0, 1'b0, 1'b1, 2'b01, 13'h001, 1'b1);
    check("R1 non-load ext", ext_word, 0);

    // R7: pulse width and A8 readback
    issue(1'b0, 1'b0, 1'b0, 2'b00, 13'h132, 1'b1);
    check("R7 pulse high", dll_rst, 1);
    check("R7 a8 reads zero", mode_word, 13'h032);
    @(negedge clk);
    check("R7 pulse one cycle", dll_rst, 0);
    check("R7 word stays", mode_word, 13'h032);

    // R10: whole extended word stored
    issue(1'b0, 1'b0, 1'b0, 2'b01, 13'h1A5, 1'b1);
    check("R10 ext stored", ext_word, 13'h1A5);
    check("R10 dll off", dll_en, 0);

    // R11: reset mid-run
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("R11 mid-run");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule